// File: doc/BRIEF.md
# Two-Way Capture Transceiver Channel

This block joins two parallel data ports, called A and B, with one independent path in each direction. The A-to-B path drives port B and the B-to-A path drives port A. Each path has four controls of its own: an active-low output enable, a latch enable, a capture clock and an active-low capture-clock enable. With these controls a path can pass data straight through, freeze it like an open-then-closed latch, or store it on a falling edge of its capture clock. Data is never inverted.

The block runs on one system clock. It does not use tri-state pins. Each port is presented as a data-out vector and a one-bit drive enable, and the surrounding pad logic does the actual driving. The latch enable, capture clock, capture-clock enable and data are sampled into the system clock domain by a two-stage synchronizer. A falling capture edge is found by comparing two consecutive synchronized samples. Reaction to these inputs therefore lags by a few system clocks. The output enables act at once.

Each path holds a three-state controller:
- ST_OFF (`LN_OFF`) is the state held during power-up reset.
- ST_PASS (`LN_PASS`) is the transparent state.
- ST_HOLD (`LN_HOLD`) is the storing state.

Its transitions are:
- release (OFF to PASS or HOLD, chosen by the synchronized latch enable).
- close (PASS to HOLD when the latch enable goes low).
- open (HOLD to PASS when the latch enable goes high).

Top module: `bidir_capture_xcvr`

## Requirements
- R1: While `rst_n` is low, both drive enables and `bus_clash` are 0, and both data outputs are all-zero. The stored values of both paths are cleared to zero.
- R2: While a path's latch enable is 1, its output equals its input data, non-inverted, within 4 system clocks of a change. This holds whatever its capture clock does.
- R3: While the latch enable is 0 and the capture-clock enable is 0, a 1-to-0 transition of the capture clock stores the data that was present while the clock was 1. The output then shows that stored value.
- R4: While the latch enable is 0 and the capture clock stays at a constant level (either 0 or 1), the output keeps its stored value whatever the input data does.
- R5: While the capture-clock enable is 1, falling capture edges are ignored and the stored value is kept.
- R6: A path's drive enable is 1 exactly when its output enable is 0 and reset is released. It responds to the output enable in the same cycle.
- R7: The two paths are independent. The controls and data of one path never change the other path's output or drive enable.
- R8: `bus_clash` is 1 whenever both drive enables are 1.
- R9: When the latch enable falls, the output keeps the last value that passed through in transparent mode.
- R10: A 0-to-1 transition of the capture clock never stores data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous assert |
| a_in | input | W | Data arriving on port A |
| b_in | input | W | Data arriving on port B |
| a2b_oe_n | input | 1 | A-to-B output enable, active low |
| a2b_le | input | 1 | A-to-B latch enable, 1 = transparent |
| a2b_cp | input | 1 | A-to-B capture clock, falling edge stores |
| a2b_ce_n | input | 1 | A-to-B capture-clock enable, active low |
| b2a_oe_n | input | 1 | B-to-A output enable, active low |
| b2a_le | input | 1 | B-to-A latch enable, 1 = transparent |
| b2a_cp | input | 1 | B-to-A capture clock, falling edge stores |
| b2a_ce_n | input | 1 | B-to-A capture-clock enable, active low |
| b_out | output | W | Data to drive onto port B |
| b_drv_en | output | 1 | Port B drive enable |
| a_out | output | W | Data to drive onto port A |
| a_drv_en | output | 1 | Port A drive enable |
| bus_clash | output | 1 | Both ports driving at once |

## Verification
A wrong controller state appears at the data outputs within about four system clocks.
- A path stuck in PASS keeps tracking input data that should be frozen.
- A path stuck in HOLD ignores input data that should flow through.
- A wrongly updated stored value shows as a stale or early word after a capture edge, or after the latch closes.

The stimulus therefore changes input data while the path is frozen, and samples after the synchronizer delay has settled. A wrong drive-enable decision appears on the same cycle as the output-enable change, and the checks sample it right away.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    typedef enum logic [1:0] {
        LN_OFF  = 2'd0,
        LN_PASS = 2'd1,
        LN_HOLD = 2'd2
    } lane_state_e;

    localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync #(
    parameter int   W       = 1,
    parameter int   DEPTH   = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [DEPTH-1:0][W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {DEPTH{{W{RST_VAL}}}};
        end else begin
            for (int i = DEPTH - 1; i > 0; i--) begin
                stage_q[i] <= stage_q[i-1];
            end
            stage_q[0] <= d;
        end
    end

    assign q = stage_q[DEPTH-1];
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         oe_n,
    input  logic         le,
    input  logic         cp,
    input  logic         ce_n,
    output logic [W-1:0] dout,
    output logic         drv_en
);
    logic [W-1:0] data_s2;
    logic [W-1:0] data_s3;
    logic         le_s, cp_s, ce_s, cp_s3;
    logic         fall;
    logic [W-1:0] held_q;
    lane_state_e  state_q, state_d;

    xcvr_sync #(.W(W), .DEPTH(SYNC_DEPTH), .RST_VAL(1'b0)) u_data_sync (
        .clk(clk), .rst_n(rst_n), .d(din), .q(data_s2));
    xcvr_sync #(.W(2), .DEPTH(SYNC_DEPTH), .RST_VAL(1'b0)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d({le, cp}), .q({le_s, cp_s}));
    xcvr_sync #(.W(1), .DEPTH(SYNC_DEPTH), .RST_VAL(1'b1)) u_ce_sync (
        .clk(clk), .rst_n(rst_n), .d(ce_n), .q(ce_s));

    // one more stage: data and clock level from the previous sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_s3 <= '0;
            cp_s3   <= 1'b0;
        end else begin
            data_s3 <= data_s2;
            cp_s3   <= cp_s;
        end
    end

    assign fall = cp_s3 && !cp_s;

    // next-state logic: release, close, open
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_OFF:  state_d = le_s ? LN_PASS : LN_HOLD;
            LN_PASS: if (!le_s) state_d = LN_HOLD;
            LN_HOLD: if (le_s)  state_d = LN_PASS;
            default: state_d = LN_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_OFF;
        else        state_q <= state_d;
    end

    // storage element: tracks while open, captures on enabled falling edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else begin
            unique case (state_q)
                LN_PASS: held_q <= data_s2;
                LN_HOLD: if (fall && !ce_s) held_q <= data_s3;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            LN_PASS: dout = data_s2;
            LN_HOLD: dout = held_q;
            default: dout = held_q;
        endcase
        drv_en = (state_q != LN_OFF) && !oe_n;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_quiet_in_reset: assert (!drv_en && held_q == '0 && state_q == LN_OFF)
                else $error("R1: lane active during reset");
        end
    end

    a_r2_track_when_open: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_PASS) |=> (held_q == $past(data_s2)))
        else $error("R2: stored value not tracking in transparent state");

    a_r3_capture_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_HOLD && fall && !ce_s) |=> (held_q == $past(data_s3)))
        else $error("R3: falling edge did not capture");

    a_r4_keep_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_HOLD && !fall) |=> $stable(held_q))
        else $error("R4: stored value changed without an edge");

    a_r5_gate_blocks_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_HOLD && ce_s) |=> $stable(held_q))
        else $error("R5: gated edge changed stored value");
endmodule

// File: rtl/bidir_capture_xcvr.sv
module bidir_capture_xcvr #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         a2b_oe_n,
    input  logic         a2b_le,
    input  logic         a2b_cp,
    input  logic         a2b_ce_n,
    input  logic         b2a_oe_n,
    input  logic         b2a_le,
    input  logic         b2a_cp,
    input  logic         b2a_ce_n,
    output logic [W-1:0] b_out,
    output logic         b_drv_en,
    output logic [W-1:0] a_out,
    output logic         a_drv_en,
    output logic         bus_clash
);
    xcvr_lane #(.W(W)) u_a2b (
        .clk(clk), .rst_n(rst_n), .din(a_in),
        .oe_n(a2b_oe_n), .le(a2b_le), .cp(a2b_cp), .ce_n(a2b_ce_n),
        .dout(b_out), .drv_en(b_drv_en));

    xcvr_lane #(.W(W)) u_b2a (
        .clk(clk), .rst_n(rst_n), .din(b_in),
        .oe_n(b2a_oe_n), .le(b2a_le), .cp(b2a_cp), .ce_n(b2a_ce_n),
        .dout(a_out), .drv_en(a_drv_en));

    assign bus_clash = a_drv_en && b_drv_en;

    a_r6_fwd_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        a2b_oe_n |-> !b_drv_en)
        else $error("R6: port B driven while disabled");

    a_r6_rev_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        b2a_oe_n |-> !a_drv_en)
        else $error("R6: port A driven while disabled");

    a_r8_clash_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!a2b_oe_n && !b2a_oe_n) |-> bus_clash)
        else $error("R8: clash not flagged");
endmodule

// File: tb/bidir_capture_xcvr_tb_top.sv
module bidir_capture_xcvr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 18;
    localparam int SETTLE     = 6;
    localparam int NVEC       = 20;

    // control nibble order: {oe_n, le, cp, ce_n}
    typedef struct packed {
        logic [3:0]   fc;
        logic [W-1:0] fa;
        logic [3:0]   rc;
        logic [W-1:0] rb;
        logic [W-1:0] xb;
        logic         xbe;
        logic [W-1:0] xa;
        logic         xae;
        logic         xcl;
        logic [3:0]   req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{4'b0100, 18'h12345, 4'b1000, 18'h0AAAA, 18'h12345, 1'b1, 18'h00000, 1'b0, 1'b0, 4'd2},  // R2 pass
        '{4'b0100, 18'h3C0F0, 4'b1000, 18'h0AAAA, 18'h3C0F0, 1'b1, 18'h00000, 1'b0, 1'b0, 4'd2},  // R2 new word
        '{4'b0000, 18'h3C0F0, 4'b1000, 18'h0AAAA, 18'h3C0F0, 1'b1, 18'h00000, 1'b0, 1'b0, 4'd9},  // R9 close
        '{4'b0000, 18'h00FFF, 4'b1000, 18'h0AAAA, 18'h3C0F0, 1'b1, 18'h00000, 1'b0, 1'b0, 4'd4},  // R4 cp low
        '{4'b0010, 18'h00FFF, 4'b1000, 18'h0AAAA, 18'h3C0F0, 1'b1, 18'h00000, 1'b0, 1'b0, 4'd10}, // R10 rise
        '{4'b0000, 18'h11111, 4'b1000, 18'h0AAAA, 18'h00FFF, 1'b1, 18'h00000, 1'b0, 1'b0, 4'd3},  // R3 fall
        '{4'b0010, 18'h22222, 4'b1000, 18'h0AAAA, 18'h00FFF, 1'b1, 18'h00000, 1'b0, 1'b0, 4'd10}, // R10 rise
        '{4'b0011, 18'h22222, 4'b1000, 18'h0AAAA, 18'h00FFF, 1'b1, 18'h00000, 1'b0, 1'b0, 4'd4},  // R4 cp high
        '{4'b0001, 18'h33333, 4'b1000, 18'h0AAAA, 18'h00FFF, 1'b1, 18'h00000, 1'b0, 1'b0, 4'd5},  // R5 gated
        '{4'b0011, 18'h33333, 4'b1000, 18'h0AAAA, 18'h00FFF, 1'b1, 18'h00000, 1'b0, 1'b0, 4'd5},  // R5
        '{4'b0010, 18'h33333, 4'b1000, 18'h0AAAA, 18'h00FFF, 1'b1, 18'h00000, 1'b0, 1'b0, 4'd4},  // R4
        '{4'b0000, 18'h34567, 4'b1000, 18'h0AAAA, 18'h33333, 1'b1, 18'h00000, 1'b0, 1'b0, 4'd3},  // R3 fall
        '{4'b1000, 18'h34567, 4'b1000, 18'h0AAAA, 18'h33333, 1'b0, 18'h00000, 1'b0, 1'b0, 4'd6},  // R6 off
        '{4'b1000, 18'h34567, 4'b0100, 18'h2BCDE, 18'h33333, 1'b0, 18'h2BCDE, 1'b1, 1'b0, 4'd7},  // R7 rev
        '{4'b1000, 18'h34567, 4'b0110, 18'h15555, 18'h33333, 1'b0, 18'h15555, 1'b1, 1'b0, 4'd2},  // R2 cp ignored
        '{4'b0000, 18'h34567, 4'b0110, 18'h15555, 18'h33333, 1'b1, 18'h15555, 1'b1, 1'b1, 4'd8},  // R8 clash
        '{4'b0000, 18'h34567, 4'b0010, 18'h15555, 18'h33333, 1'b1, 18'h15555, 1'b1, 1'b1, 4'd9},  // R9 rev close
        '{4'b0000, 18'h34567, 4'b0010, 18'h0F0F0, 18'h33333, 1'b1, 18'h15555, 1'b1, 1'b1, 4'd4},  // R4 rev
        '{4'b0000, 18'h34567, 4'b0000, 18'h07777, 18'h33333, 1'b1, 18'h0F0F0, 1'b1, 1'b1, 4'd3},  // R3 rev
        '{4'b0000, 18'h3FFFF, 4'b0000, 18'h07777, 18'h33333, 1'b1, 18'h0F0F0, 1'b1, 1'b1, 4'd7}   // R7 fwd data
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         a2b_oe_n = 1'b1, a2b_le = 1'b0, a2b_cp = 1'b0, a2b_ce_n = 1'b0;
    logic         b2a_oe_n = 1'b1, b2a_le = 1'b0, b2a_cp = 1'b0, b2a_ce_n = 1'b0;
    logic [W-1:0] b_out, a_out;
    logic         b_drv_en, a_drv_en, bus_clash;
    int           n_checks = 0;
    int           n_fail = 0;
    logic         done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bidir_capture_xcvr #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .a2b_oe_n(a2b_oe_n), .a2b_le(a2b_le), .a2b_cp(a2b_cp), .a2b_ce_n(a2b_ce_n),
        .b2a_oe_n(b2a_oe_n), .b2a_le(b2a_le), .b2a_cp(b2a_cp), .b2a_ce_n(b2a_ce_n),
        .b_out(b_out), .b_drv_en(b_drv_en), .a_out(a_out), .a_drv_en(a_drv_en),
        .bus_clash(bus_clash));

    task automatic check_all(input string tag, input logic [W-1:0] xb, input logic xbe,
                             input logic [W-1:0] xa, input logic xae, input logic xcl);
        n_checks++;
        if (b_out !== xb || b_drv_en !== xbe || a_out !== xa || a_drv_en !== xae ||
            bus_clash !== xcl) begin
            n_fail++;
            $display("FAIL %s: got b=%h be=%b a=%h ae=%b cl=%b, expected b=%h be=%b a=%h ae=%b cl=%b",
                     tag, b_out, b_drv_en, a_out, a_drv_en, bus_clash, xb, xbe, xa, xae, xcl);
        end
    endtask

    task automatic apply_vec(input int idx);
        vec_t v;
        v = VECS[idx];
        {a2b_oe_n, a2b_le, a2b_cp, a2b_ce_n} = v.fc;
        {b2a_oe_n, b2a_le, b2a_cp, b2a_ce_n} = v.rc;
        a_in = v.fa;
        b_in = v.rb;
        repeat (SETTLE) @(negedge clk);
        check_all($sformatf("R%0d vector %0d", v.req, idx), v.xb, v.xbe, v.xa, v.xae, v.xcl);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet and cleared during power-up reset, even with enables low
        a2b_oe_n = 1'b0;
        b2a_oe_n = 1'b0;
        a2b_le   = 1'b1;
        a_in     = 18'h2FFFF;
        repeat (3) @(negedge clk);
        check_all("R1 power-up", '0, 1'b0, '0, 1'b0, 1'b0);
        {a2b_oe_n, a2b_le, a2b_cp, a2b_ce_n} = 4'b0100;
        {b2a_oe_n, b2a_le, b2a_cp, b2a_ce_n} = 4'b1000;
        a_in = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) apply_vec(i);

        // R6: output enable acts within the same cycle
        a2b_oe_n = 1'b1;
        #1;
        check_all("R6 immediate disable", 18'h33333, 1'b0, 18'h0F0F0, 1'b1, 1'b0);
        a2b_oe_n = 1'b0;
        #1;
        check_all("R6 R8 immediate enable", 18'h33333, 1'b1, 18'h0F0F0, 1'b1, 1'b1);

        // R1: reset in mid-run clears drive enables at once and stored values
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        n_checks++;
        if (b_drv_en !== 1'b0 || a_drv_en !== 1'b0 || bus_clash !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 async: got be=%b ae=%b cl=%b, expected 0 0 0",
                     b_drv_en, a_drv_en, bus_clash);
        end
        repeat (2) @(negedge clk);
        check_all("R1 mid-run reset", '0, 1'b0, '0, 1'b0, 1'b0);

        // R2 after release: transparent path comes back with fresh data
        {a2b_oe_n, a2b_le, a2b_cp, a2b_ce_n} = 4'b0100;
        {b2a_oe_n, b2a_le, b2a_cp, b2a_ce_n} = 4'b1000;
        a_in = 18'h2AAAA;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (SETTLE) @(negedge clk);
        check_all("R2 after reset", 18'h2AAAA, 1'b1, '0, 1'b0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule